// File: doc/BRIEF.md
# DMA Channel Trigger Qualifier

This block sits beside one channel of a DMA engine and decides when that channel may ask the arbiter for bus time. It watches one asynchronous hardware request line, brings it into the clock domain through a short synchronizer, and turns it into grants according to the channel configuration. The request line can be sensed as an edge or as a level, either active-high or active-low. A software pulse can also start the channel, but only while the current descriptor is marked valid.

Each accepted trigger loads a grant counter. With bursting off the counter is loaded with one. With bursting on in edge mode it is loaded with two raised to a configured power, clamped to a maximum. The datapath returns a pulse for each finished transfer, and each pulse uses up one grant. With bursting on in level mode the channel streams: the request stays up for as long as the synchronized level is active. When a counted burst runs out, the block tells the address generators whether to rewind the source and/or destination pointer to the start of the burst region. A clear strobe drops any grants still left.

Top module: `dma_trig_unit`

## Requirements
- R1: While `hw_trig_en` is 0, activity on `req_in` never loads grants or raises `go`; only a qualified software trigger can start the channel.
- R2: In edge mode (`trig_level`=0), a rising edge of `req_in` qualifies when `trig_pol`=1 and a falling edge qualifies when `trig_pol`=0. The line passes through two synchronizer flops, so a change on `req_in` set up before clock edge k shows in `grants_left` after edge k+2.
- R3: In level mode without bursting, an active level (high when `trig_pol`=1, low when 0) loads one grant whenever no grant is pending. It therefore reloads after each `xfer_done` for as long as the level stays active.
- R4: With `burst_en`=0, every accepted trigger loads exactly one grant.
- R5: With `burst_en`=1 and edge mode, an accepted trigger loads 2^`burst_pow` grants. Values of `burst_pow` above 10 are treated as 10 (1024 grants). A software trigger uses the same budget rule.
- R6: With `burst_en`=1 and level mode, `go` follows the synchronized active level, and no grants are counted for it.
- R7: While grants are pending, new edges, levels and software triggers are ignored, and `grants_left` changes only through `xfer_done` or `clr_trig`.
- R8: `sw_trig` loads grants only in a cycle where `desc_valid` is 1.
- R9: `clr_trig` sets `grants_left` to 0 on the next edge and takes priority over both a trigger and a done pulse in the same cycle.
- R10: When a `xfer_done` uses the last pending grant, `src_rewind` and/or `dst_rewind` pulse for one cycle on the following cycle, each gated by its own enable (`src_wrap_en`, `dst_wrap_en`). No pulse follows a clear.
- R11: Each `xfer_done` with grants pending reduces `grants_left` by one. `go` is high exactly when grants are pending or level streaming is active.
- R12: After reset, `go`, `grants_left`, `src_rewind` and `dst_rewind` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_trig_en | input | 1 | Enable sensing of `req_in` |
| trig_level | input | 1 | 1 = level-sensitive, 0 = edge-sensitive |
| trig_pol | input | 1 | 1 = high/rising active, 0 = low/falling active |
| burst_en | input | 1 | Enable multi-transfer bursts |
| burst_pow | input | POW_W (4) | Burst size exponent, clamped to MAX_POW |
| src_wrap_en | input | 1 | Rewind source pointer after each burst |
| dst_wrap_en | input | 1 | Rewind destination pointer after each burst |
| req_in | input | 1 | Asynchronous hardware request line |
| sw_trig | input | 1 | Software trigger pulse |
| desc_valid | input | 1 | Current descriptor is valid |
| clr_trig | input | 1 | Drop remaining grants |
| xfer_done | input | 1 | One transfer finished |
| go | output | 1 | Request to the channel arbiter |
| grants_left | output | CNT_W (11) | Grants remaining in the current burst |
| src_rewind | output | 1 | One-cycle pulse: restart source address |
| dst_rewind | output | 1 | One-cycle pulse: restart destination address |

## Verification
The bench builds the block with its defaults: two synchronizer stages, a 4-bit power field and a maximum power of 10. This puts the largest 1024-grant burst within reach, as well as the clamp of power codes 11 to 15 onto it. The defaults also fix the three-edge latency from `req_in` to a loaded counter, and a cycle-level model in the bench tracks that latency. Directed phases cover each sensing mode and polarity, triggers ignored during a burst, clears, and rewinds. A long randomized phase then mixes configuration changes with request, done and clear traffic.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;

  // Active sense of the synchronized request line
  function automatic logic sense_active(input logic raw, input logic pol);
    return pol ? raw : ~raw;
  endfunction

  // Edge of interest: rising for pol=1, falling for pol=0
  function automatic logic sense_edge(input logic cur, input logic prev, input logic pol);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Grant budget for one accepted trigger
  function automatic int unsigned grant_budget(input logic en, input int unsigned pow,
                                               input int unsigned max_pow);
    int unsigned p;
    p = (pow > max_pow) ? max_pow : pow;
    return en ? (32'd1 << p) : 32'd1;
  endfunction

endpackage

// File: rtl/dma_trig_sync.sv
module dma_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  output logic req_s,
  output logic req_d
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg   <= '0;
      req_d <= 1'b0;
    end else begin
      stg   <= {stg[STAGES-2:0], req_in};
      req_d <= stg[STAGES-1];
    end
  end

  assign req_s = stg[STAGES-1];
endmodule

// File: rtl/dma_trig_qualify.sv
module dma_trig_qualify
  import dma_trig_pkg::*;
(
  input  logic hw_trig_en,
  input  logic trig_level,
  input  logic trig_pol,
  input  logic burst_en,
  input  logic req_s,
  input  logic req_d,
  input  logic sw_trig,
  input  logic desc_valid,
  input  logic clr_trig,
  input  logic idle,
  output logic edge_evt,
  output logic level_act,
  output logic hw_fire,
  output logic sw_fire,
  output logic trig_accept,
  output logic stream_go
);
  always_comb begin
    level_act   = sense_active(req_s, trig_pol);
    edge_evt    = sense_edge(req_s, req_d, trig_pol);
    hw_fire     = hw_trig_en & (trig_level ? (level_act & ~burst_en) : edge_evt);
    sw_fire     = sw_trig & desc_valid;
    trig_accept = idle & ~clr_trig & (hw_fire | sw_fire);
    stream_go   = hw_trig_en & trig_level & burst_en & level_act;
  end
endmodule

// File: rtl/dma_trig_burst_ctr.sv
module dma_trig_burst_ctr
  import dma_trig_pkg::*;
#(
  parameter int POW_W   = 4,
  parameter int MAX_POW = 10,
  parameter int CNT_W   = MAX_POW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_accept,
  input  logic             burst_en,
  input  logic [POW_W-1:0] burst_pow,
  input  logic             xfer_done,
  input  logic             clr_trig,
  input  logic             src_wrap_en,
  input  logic             dst_wrap_en,
  output logic [CNT_W-1:0] cnt,
  output logic             idle,
  output logic             burst_end,
  output logic             src_rewind,
  output logic             dst_rewind
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] budget;

  always_comb begin
    budget    = CNT_W'(grant_budget(burst_en, 32'(burst_pow), MAX_POW));
    idle      = (cnt == '0);
    burst_end = xfer_done & (cnt == ONE) & ~clr_trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr_trig) begin
      cnt <= '0;
    end else if (trig_accept) begin
      cnt <= budget;
    end else if (xfer_done && !idle) begin
      cnt <= cnt - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_rewind <= 1'b0;
      dst_rewind <= 1'b0;
    end else begin
      src_rewind <= burst_end & src_wrap_en;
      dst_rewind <= burst_end & dst_wrap_en;
    end
  end
endmodule

// File: rtl/dma_trig_unit.sv
module dma_trig_unit #(
  parameter int SYNC_STAGES = 2,
  parameter int POW_W       = 4,
  parameter int MAX_POW     = 10,
  localparam int CNT_W      = MAX_POW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_trig_en,
  input  logic             trig_level,
  input  logic             trig_pol,
  input  logic             burst_en,
  input  logic [POW_W-1:0] burst_pow,
  input  logic             src_wrap_en,
  input  logic             dst_wrap_en,
  input  logic             req_in,
  input  logic             sw_trig,
  input  logic             desc_valid,
  input  logic             clr_trig,
  input  logic             xfer_done,
  output logic             go,
  output logic [CNT_W-1:0] grants_left,
  output logic             src_rewind,
  output logic             dst_rewind
);
  // Named internal events, visible to the checker
  logic req_s, req_d;
  logic edge_evt, level_act, hw_fire, sw_fire;
  logic trig_accept, stream_go, idle, burst_end;

  dma_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .req_in(req_in),
    .req_s (req_s),
    .req_d (req_d)
  );

  dma_trig_qualify u_qual (
    .hw_trig_en (hw_trig_en),
    .trig_level (trig_level),
    .trig_pol   (trig_pol),
    .burst_en   (burst_en),
    .req_s      (req_s),
    .req_d      (req_d),
    .sw_trig    (sw_trig),
    .desc_valid (desc_valid),
    .clr_trig   (clr_trig),
    .idle       (idle),
    .edge_evt   (edge_evt),
    .level_act  (level_act),
    .hw_fire    (hw_fire),
    .sw_fire    (sw_fire),
    .trig_accept(trig_accept),
    .stream_go  (stream_go)
  );

  dma_trig_burst_ctr #(
    .POW_W  (POW_W),
    .MAX_POW(MAX_POW),
    .CNT_W  (CNT_W)
  ) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_accept(trig_accept),
    .burst_en   (burst_en),
    .burst_pow  (burst_pow),
    .xfer_done  (xfer_done),
    .clr_trig   (clr_trig),
    .src_wrap_en(src_wrap_en),
    .dst_wrap_en(dst_wrap_en),
    .cnt        (grants_left),
    .idle       (idle),
    .burst_end  (burst_end),
    .src_rewind (src_rewind),
    .dst_rewind (dst_rewind)
  );

  assign go = ~idle | stream_go;
endmodule

// File: rtl/dma_trig_unit_chk.sv
module dma_trig_unit_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_trig_en,
  input logic             sw_trig,
  input logic             desc_valid,
  input logic             clr_trig,
  input logic             xfer_done,
  input logic             src_wrap_en,
  input logic             dst_wrap_en,
  input logic [CNT_W-1:0] grants_left,
  input logic             src_rewind,
  input logic             dst_rewind,
  input logic             trig_accept,
  input logic             burst_end
);
  // R1
  no_hw_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_trig_en && !sw_trig && grants_left == '0 && !clr_trig) |=> grants_left == '0);

  // R5
  onehot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_accept |=> $countones(grants_left) == 1);

  // R7
  hold_during_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grants_left != '0 && !clr_trig && !xfer_done) |=> $stable(grants_left));

  // R8
  sw_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_trig && !desc_valid && !hw_trig_en && grants_left == '0) |=> grants_left == '0);

  // R9
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_trig |=> grants_left == '0);

  // R10
  src_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && src_wrap_en) |=> src_rewind);

  // R10
  dst_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_rewind |-> $past(dst_wrap_en && xfer_done && !clr_trig));

  // R11
  done_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !clr_trig && grants_left > CNT_W'(1)) |=>
      grants_left == $past(grants_left) - CNT_W'(1));
endmodule

bind dma_trig_unit dma_trig_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hw_trig_en (hw_trig_en),
  .sw_trig    (sw_trig),
  .desc_valid (desc_valid),
  .clr_trig   (clr_trig),
  .xfer_done  (xfer_done),
  .src_wrap_en(src_wrap_en),
  .dst_wrap_en(dst_wrap_en),
  .grants_left(grants_left),
  .src_rewind (src_rewind),
  .dst_rewind (dst_rewind),
  .trig_accept(trig_accept),
  .burst_end  (burst_end)
);

// File: tb/dma_trig_unit_bench.sv
`timescale 1ns/1ps
module dma_trig_unit_bench;
  localparam int CW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_trig_en = 0, trig_level = 0, trig_pol = 1, burst_en = 0;
  logic [3:0] burst_pow = 0;
  logic src_wrap_en = 0, dst_wrap_en = 0, req_in = 0;
  logic sw_trig = 0, desc_valid = 0, clr_trig = 0, xfer_done = 0;
  logic go, src_rewind, dst_rewind;
  logic [CW-1:0] grants_left;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit cmp_on = 0;
  string phase = "R12";

  always #5 clk = ~clk;

  dma_trig_unit u_dma_trig_unit (
    .clk(clk), .rst_n(rst_n), .hw_trig_en(hw_trig_en), .trig_level(trig_level),
    .trig_pol(trig_pol), .burst_en(burst_en), .burst_pow(burst_pow),
    .src_wrap_en(src_wrap_en), .dst_wrap_en(dst_wrap_en), .req_in(req_in),
    .sw_trig(sw_trig), .desc_valid(desc_valid), .clr_trig(clr_trig),
    .xfer_done(xfer_done), .go(go), .grants_left(grants_left),
    .src_rewind(src_rewind), .dst_rewind(dst_rewind));

  // Behavioural reference: synchronizer as a queue of samples, counter as an integer
  bit sq[$] = '{0, 0, 0};
  int m_cnt = 0;
  bit m_src = 0, m_dst = 0;

  function automatic bit m_act();
    return trig_pol ? sq[1] : !sq[1];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      sq = '{0, 0, 0};
      m_cnt = 0; m_src = 0; m_dst = 0;
    end else begin
      bit act, edg, hwreq, swreq, fin;
      int p, budget;
      act = m_act();
      edg = trig_pol ? (sq[1] && !sq[2]) : (!sq[1] && sq[2]);
      p = (burst_pow > 10) ? 10 : int'(burst_pow);
      budget = burst_en ? (1 << p) : 1;
      hwreq = hw_trig_en && (trig_level ? (act && !burst_en) : edg);
      swreq = sw_trig && desc_valid;
      fin = xfer_done && m_cnt == 1 && !clr_trig;
      m_src = fin && src_wrap_en;
      m_dst = fin && dst_wrap_en;
      if (clr_trig) m_cnt = 0;
      else if (m_cnt == 0 && (hwreq || swreq)) m_cnt = budget;
      else if (xfer_done && m_cnt > 0) m_cnt = m_cnt - 1;
      sq.push_front(req_in);
      void'(sq.pop_back());
    end
  end

  task automatic chk(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle compare, well away from both clock edges
  always @(posedge clk) begin
    #4;
    if (cmp_on) begin
      bit eg;
      eg = (m_cnt != 0) || (hw_trig_en && trig_level && burst_en && m_act());
      chk(int'(go), int'(eg), phase, "go");
      chk(int'(grants_left), m_cnt, phase, "grants_left");
      chk(int'(src_rewind), int'(m_src), phase, "src_rewind");
      chk(int'(dst_rewind), int'(m_dst), phase, "dst_rewind");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk) xfer_done = 1;
    @(negedge clk) xfer_done = 0;
  endtask

  task automatic clear_all();
    @(negedge clk) clr_trig = 1;
    @(negedge clk) clr_trig = 0;
  endtask

  initial begin
    wait_n(3);
    // R12: reset state
    chk(go, 0, "R12", "go in reset");
    chk(grants_left, 0, "R12", "grants in reset");
    chk(src_rewind | dst_rewind, 0, "R12", "rewind in reset");
    @(negedge clk) rst_n = 1;
    cmp_on = 1;
    wait_n(2);

    // R1: request line ignored while hw disabled
    phase = "R1";
    hw_trig_en = 0; trig_level = 0; trig_pol = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) req_in = ~req_in;
    end
    @(negedge clk) req_in = 0;
    wait_n(4);
    chk(go, 0, "R1", "go with hw off");
    chk(grants_left, 0, "R1", "grants with hw off");

    // R2 + R4: rising edge, single transfer
    phase = "R2";
    hw_trig_en = 1; burst_en = 0;
    wait_n(3);
    req_in = 1;
    wait_n(2);
    chk(grants_left, 0, "R2", "not loaded before sync latency");
    wait_n(1);
    chk(grants_left, 1, "R4", "one grant after rising edge");
    chk(go, 1, "R2", "go after rising edge");
    req_in = 0;
    wait_n(3);
    phase = "R4";
    done_pulse();
    wait_n(4);
    chk(grants_left, 0, "R4", "single grant consumed");
    chk(go, 0, "R4", "go after single grant");

    // R2: falling polarity ignores rising edge
    phase = "R2";
    trig_pol = 0;
    wait_n(2);
    req_in = 1;
    wait_n(4);
    chk(grants_left, 0, "R2", "rising ignored with pol=0");
    req_in = 0;
    wait_n(3);
    chk(grants_left, 1, "R2", "falling edge loads with pol=0");
    done_pulse();
    wait_n(2);

    // R5 + R10 + R11: edge burst of 8, source wrap only
    phase = "R5";
    trig_pol = 1; burst_en = 1; burst_pow = 3; src_wrap_en = 1; dst_wrap_en = 0;
    wait_n(2);
    req_in = 1;
    wait_n(3);
    chk(grants_left, 8, "R5", "burst of 2^3");
    req_in = 0;
    phase = "R11";
    for (int i = 0; i < 7; i++) begin
      done_pulse();
      chk(grants_left, 7 - i, "R11", "decrement per done");
    end
    phase = "R10";
    @(negedge clk) xfer_done = 1;
    @(negedge clk) xfer_done = 0;
    chk(src_rewind, 1, "R10", "src rewind at burst end");
    chk(dst_rewind, 0, "R10", "dst rewind disabled");
    chk(go, 0, "R11", "go low at zero");
    wait_n(1);
    chk(src_rewind, 0, "R10", "rewind is one cycle");

    // R7: triggers during a burst are ignored; R8 software gating
    phase = "R8";
    hw_trig_en = 0; burst_pow = 2; desc_valid = 0;
    @(negedge clk) sw_trig = 1;
    @(negedge clk) sw_trig = 0;
    chk(grants_left, 0, "R8", "sw ignored without valid");
    desc_valid = 1;
    @(negedge clk) sw_trig = 1;
    @(negedge clk) sw_trig = 0;
    chk(grants_left, 4, "R8", "sw with valid loads");
    phase = "R7";
    hw_trig_en = 1;
    done_pulse();
    req_in = 1;
    @(negedge clk) sw_trig = 1;
    @(negedge clk) sw_trig = 0;
    wait_n(4);
    chk(grants_left, 3, "R7", "edge and sw ignored mid-burst");
    req_in = 0;
    wait_n(3);

    // R9: clear drops remaining grants, no rewind
    phase = "R9";
    @(negedge clk) begin clr_trig = 1; xfer_done = 1; end
    @(negedge clk) begin clr_trig = 0; xfer_done = 0; end
    chk(grants_left, 0, "R9", "clear drops grants");
    chk(src_rewind, 0, "R9", "no rewind after clear");
    wait_n(1);

    // R5: clamp of power 15 to 1024, dst wrap
    phase = "R5";
    hw_trig_en = 0; burst_pow = 15; src_wrap_en = 0; dst_wrap_en = 1;
    @(negedge clk) sw_trig = 1;
    @(negedge clk) sw_trig = 0;
    chk(grants_left, 1024, "R5", "power clamped to 10");
    xfer_done = 1;
    wait_n(1024);
    xfer_done = 0;
    chk(grants_left, 0, "R5", "1024 grants consumed");
    chk(dst_rewind, 1, "R10", "dst rewind at burst end");
    wait_n(2);

    // R3: level mode without burst reloads
    phase = "R3";
    desc_valid = 0; burst_en = 0; trig_level = 1; trig_pol = 1; hw_trig_en = 1;
    wait_n(2);
    req_in = 1;
    wait_n(3);
    chk(grants_left, 1, "R3", "level loads one grant");
    done_pulse();
    wait_n(1);
    chk(grants_left, 1, "R3", "level reloads after done");
    req_in = 0;
    wait_n(3);
    done_pulse();
    wait_n(3);
    chk(go, 0, "R3", "no reload after level drops");

    // R6: level streaming, active low
    phase = "R6";
    hw_trig_en = 0; burst_en = 1; trig_pol = 0;
    wait_n(1);
    hw_trig_en = 1;
    wait_n(1);
    chk(go, 1, "R6", "stream while low");
    chk(grants_left, 0, "R6", "no grants counted in stream");
    req_in = 1;
    wait_n(3);
    chk(go, 0, "R6", "stream stops when level inactive");
    req_in = 0;
    hw_trig_en = 0;
    clear_all();

    // R11: randomized mix, compared every cycle against the model
    phase = "R11";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (i % 64 == 0) begin
        hw_trig_en = $urandom_range(0, 3) != 0;
        trig_level = $urandom_range(0, 1);
        trig_pol = $urandom_range(0, 1);
        burst_en = $urandom_range(0, 1);
        burst_pow = 4'($urandom_range(0, 5));
        src_wrap_en = $urandom_range(0, 1);
        dst_wrap_en = $urandom_range(0, 1);
      end
      if ($urandom_range(0, 7) == 0) req_in = ~req_in;
      xfer_done = $urandom_range(0, 1);
      sw_trig = $urandom_range(0, 15) == 0;
      desc_valid = $urandom_range(0, 1);
      clr_trig = $urandom_range(0, 99) == 0;
    end
    @(negedge clk);
    xfer_done = 0; sw_trig = 0; clr_trig = 0;
    wait_n(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule